// File: doc/BRIEF.md
# Zero-Turnaround Pipelined SRAM

This block is a synchronous single-port memory whose command path is fully registered, so reads and writes may alternate on every clock without an idle cycle when the data bus changes direction. A command is taken on a rising edge. A read returns its word on the following edge. A write takes its address on one edge and its data two enabled edges later, so the data slot of a write lines up with the read-data slot of the next command. A clock-enable input freezes the whole pipeline for a cycle. The memory is split into 9-bit byte lanes. Each lane can be written on its own.

A load/advance input chooses between a fresh command and a continuation. A fresh command takes its address, its direction and its select state from the pins. A continuation keeps the direction and select state of the previous command and takes its address from an external next-address input, so the burst sequence is produced outside this block. Because write data lands two edges late, a read can address a word whose write has not reached the array yet. The read port merges such data lane by lane from the write bus.

Top module: `nts_sram`

## Requirements
- R1: A fresh command (clk_en_n=0, load_n=0) is accepted only when sel1_n=0, sel2=1 and sel3_n=0. It is a read when wr_n=1 and a write when wr_n=0. Any other select pattern makes the cycle a deselect, and no data is driven for it.
- R2: The word addressed by a read accepted on enabled edge N appears on rdata after enabled edge N+1. A new command may be accepted on that same edge.
- R3: For a write accepted on enabled edge N, the wdata present at enabled edge N+2 is written to the address taken at N.
- R4: An edge with clk_en_n=1 changes nothing: the command pipeline, rdata, drive_en and the array all hold, and no write is performed.
- R5: bw_n is active low, one bit per 9-bit lane: bw_n[0] guards bits 8:0 and bw_n[1] guards bits 17:9. Unselected lanes keep their contents. A write with bw_n=2'b11 changes no bit.
- R6: drive_en is 0 during the data phase of a write, whatever oe_n is.
- R7: A deselect accepted on edge N makes drive_en 0 after edge N+1.
- R8: After a reset edge (rst_n=0), drive_en is 0 and no earlier read is driven.
- R9: A read with oe_n=1 still updates rdata, but drive_en stays 0. drive_en follows oe_n without a clock.
- R10: A read that addresses a write whose data has not reached the array returns that write's data in its enabled lanes and the array contents in the other lanes.
- R11: With load_n=1, the previous command type continues at next_addr. The select inputs and wr_n are ignored. A continuation after a deselect stays deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en_n | input | 1 | Edge qualifier, active low; high stalls the block |
| sel1_n | input | 1 | Select, active low |
| sel2 | input | 1 | Select, active high |
| sel3_n | input | 1 | Select, active low |
| load_n | input | 1 | Low: fresh command; high: continue at next_addr |
| wr_n | input | 1 | Low: write, high: read (fresh commands only) |
| bw_n | input | LANES | Per-lane write selects, active low |
| addr | input | ADDR_W | Address of a fresh command |
| next_addr | input | ADDR_W | Address used by a continuation |
| wdata | input | LANES*LANE_W | Write data, sampled two enabled edges after its address |
| oe_n | input | 1 | Output enable, active low, not clocked |
| rdata | output | LANES*LANE_W | Registered read data |
| drive_en | output | 1 | High when rdata must be driven onto the bus |

## Verification
The embedded properties check on every cycle that a stalled edge leaves the pipeline and the read register unchanged. They also check that the data phase of a write and the cycle after a deselect never drive, that reset silences the output, that a continuation after a deselect stays idle, and that a read fully covered by an in-flight write returns the bus data. Only the bench scenarios can show that the returned words are correct. This covers partial-lane merging during forwarding, writes that land after a stall, aborted writes, dummy reads, and continuation addresses, all checked against a reference memory under long random mixes of back-to-back traffic.

// File: rtl/nts_pkg.sv
// Shared types for the zero-turnaround SRAM.
package nts_pkg;
    // Kind of command held in a pipeline stage.
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;
endpackage

// File: rtl/nts_cmd_pipe.sv
// Command pipeline: decodes a fresh command or continuation and carries it
// through two stages (address stage s1, data stage s2).
// Assumes: step is the qualified clock enable; reset is synchronous.
module nts_cmd_pipe
    import nts_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              sel_ok,
    input  logic              load_n,
    input  logic              wr_n,
    input  logic [LANES-1:0]  bw_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] next_addr,
    output op_e               s1_op,
    output logic [ADDR_W-1:0] s1_addr,
    output op_e               s2_op,
    output logic [ADDR_W-1:0] s2_addr,
    output logic [LANES-1:0]  s2_be
);
    op_e               nx_op;
    logic [ADDR_W-1:0] nx_addr;
    logic [LANES-1:0]  s1_be;

    // Choose between a fresh command and a continuation of the last one.
    always_comb begin
        if (!load_n) begin
            nx_addr = addr;
            if (!sel_ok)   nx_op = OP_IDLE;
            else if (wr_n) nx_op = OP_READ;
            else           nx_op = OP_WRITE;
        end else begin
            nx_addr = next_addr;
            nx_op   = s1_op;
        end
    end

    // Address stage: captures the command on every enabled edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_op   <= OP_IDLE;
            s1_addr <= '0;
            s1_be   <= '0;
        end else if (step) begin
            s1_op   <= nx_op;
            s1_addr <= nx_addr;
            s1_be   <= ~bw_n;
        end
    end

    // Data stage: the command whose write data is on the bus now.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_op   <= OP_IDLE;
            s2_addr <= '0;
            s2_be   <= '0;
        end else if (step) begin
            s2_op   <= s1_op;
            s2_addr <= s1_addr;
            s2_be   <= s1_be;
        end
    end

    AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> ($stable(s1_op) && $stable(s1_addr) && $stable(s2_op) && $stable(s2_addr))); // R4

    AST_ADVANCE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && load_n && s1_op == OP_IDLE) |=> (s1_op == OP_IDLE)); // R11
endmodule

// File: rtl/nts_lane_array.sv
// Storage split into byte lanes, each with its own write strobe.
// Assumes: one synchronous write port and one combinational read port.
module nts_lane_array #(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                      clk,
    input  logic [LANES-1:0]          we,
    input  logic [ADDR_W-1:0]         waddr,
    input  logic [LANES*LANE_W-1:0]   wdata,
    input  logic [ADDR_W-1:0]         raddr,
    output logic [LANES*LANE_W-1:0]   rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // Lane write: only when this lane's strobe is set.
        always_ff @(posedge clk) begin
            if (we[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
    end
endmodule

// File: rtl/nts_read_port.sv
// Read port: merges in-flight write data lane by lane, registers the result,
// and gates the drive flag with the unclocked output enable.
// Assumes: the only write not yet in the array is the one in the data stage.
module nts_read_port
    import nts_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step,
    input  op_e                     s1_op,
    input  logic [ADDR_W-1:0]       s1_addr,
    input  op_e                     s2_op,
    input  logic [ADDR_W-1:0]       s2_addr,
    input  logic [LANES-1:0]        s2_be,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [LANES*LANE_W-1:0] core_q,
    input  logic                    oe_n,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    drive_en
);
    localparam int DW = LANES * LANE_W;

    logic          hit;
    logic [DW-1:0] merged;
    logic          out_valid;

    assign hit = (s2_op == OP_WRITE) && (s2_addr == s1_addr);

    for (genvar g = 0; g < LANES; g++) begin : g_fwd
        assign merged[g*LANE_W +: LANE_W] = (hit && s2_be[g]) ? wdata[g*LANE_W +: LANE_W]
                                                              : core_q[g*LANE_W +: LANE_W];
    end

    // Output register: updated only by reads, held on stalls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            rdata     <= '0;
        end else if (step) begin
            out_valid <= (s1_op == OP_READ);
            if (s1_op == OP_READ) rdata <= merged;
        end
    end

    assign drive_en = out_valid & ~oe_n;

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> ($stable(rdata) && $stable(out_valid))); // R4

    AST_FULL_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        (step && s1_op == OP_READ && hit && s2_be == '1) |=> (rdata == $past(wdata))); // R10
endmodule

// File: rtl/nts_sram.sv
// Top of the zero-turnaround SRAM: select decode, command pipeline,
// lane storage and read port.
// Assumes: burst addresses are supplied on next_addr by the surrounding logic.
module nts_sram
    import nts_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_en_n,
    input  logic                    sel1_n,
    input  logic                    sel2,
    input  logic                    sel3_n,
    input  logic                    load_n,
    input  logic                    wr_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [ADDR_W-1:0]       next_addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    oe_n,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    drive_en
);
    localparam int DW = LANES * LANE_W;

    logic              step;
    logic              sel_ok;
    op_e               s1_op;
    op_e               s2_op;
    logic [ADDR_W-1:0] s1_addr;
    logic [ADDR_W-1:0] s2_addr;
    logic [LANES-1:0]  s2_be;
    logic [LANES-1:0]  lane_we;
    logic [DW-1:0]     core_q;

    assign step    = ~clk_en_n;
    assign sel_ok  = ~sel1_n & sel2 & ~sel3_n;
    assign lane_we = (step && s2_op == OP_WRITE) ? s2_be : '0;

    nts_cmd_pipe #(.ADDR_W(ADDR_W), .LANES(LANES)) u_pipe (
        .clk(clk), .rst_n(rst_n), .step(step), .sel_ok(sel_ok),
        .load_n(load_n), .wr_n(wr_n), .bw_n(bw_n), .addr(addr),
        .next_addr(next_addr), .s1_op(s1_op), .s1_addr(s1_addr),
        .s2_op(s2_op), .s2_addr(s2_addr), .s2_be(s2_be)
    );

    nts_lane_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
        .clk(clk), .we(lane_we), .waddr(s2_addr), .wdata(wdata),
        .raddr(s1_addr), .rdata(core_q)
    );

    nts_read_port #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_rd (
        .clk(clk), .rst_n(rst_n), .step(step), .s1_op(s1_op),
        .s1_addr(s1_addr), .s2_op(s2_op), .s2_addr(s2_addr), .s2_be(s2_be),
        .wdata(wdata), .core_q(core_q), .oe_n(oe_n), .rdata(rdata),
        .drive_en(drive_en)
    );

    AST_WRITE_PHASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !load_n && sel_ok && !wr_n) ##1 !clk_en_n |=> !drive_en); // R6

    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !load_n && !sel_ok) ##1 !clk_en_n |=> !drive_en); // R7

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !drive_en); // R8
endmodule

// File: tb/tb_nts_sram.sv
module tb_nts_sram;
    localparam int AW = 10;
    localparam int LW = 9;
    localparam int NL = 2;
    localparam int DW = LW * NL;
    localparam int DEPTH = 1 << AW;
    localparam int NV = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en_n = 1'b0;
    logic          sel1_n = 1'b1, sel2 = 1'b0, sel3_n = 1'b1;
    logic          load_n = 1'b0, wr_n = 1'b1;
    logic [NL-1:0] bw_n = '1;
    logic [AW-1:0] addr = '0, next_addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          oe_n = 1'b0;
    logic [DW-1:0] rdata;
    logic          drive_en;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    nts_sram #(.ADDR_W(AW), .LANE_W(LW), .LANES(NL)) dut (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel1_n(sel1_n),
        .sel2(sel2), .sel3_n(sel3_n), .load_n(load_n), .wr_n(wr_n),
        .bw_n(bw_n), .addr(addr), .next_addr(next_addr), .wdata(wdata),
        .oe_n(oe_n), .rdata(rdata), .drive_en(drive_en)
    );

    // Stimulus row applied before an edge; expected outputs after that edge.
    typedef struct packed {
        logic          en_n;
        logic          cs;
        logic          ld_n;
        logic          wrn;
        logic [1:0]    bwn;
        logic [AW-1:0] a;
        logic [DW-1:0] wd;
        logic          oen;
        logic          chk;
        logic          drv;
        logic [DW-1:0] q;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b1,1'b0,1'b0,2'b00,10'd5,18'h00000,1'b1,1'b0,1'b0,18'h00000},
        '{1'b0,1'b1,1'b0,1'b0,2'b00,10'd6,18'h00000,1'b1,1'b0,1'b0,18'h00000},
        '{1'b0,1'b1,1'b0,1'b1,2'b00,10'd5,18'h12345,1'b0,1'b0,1'b0,18'h00000},
        '{1'b0,1'b1,1'b0,1'b1,2'b00,10'd6,18'h0ABCD,1'b0,1'b1,1'b1,18'h12345},
        '{1'b0,1'b1,1'b0,1'b0,2'b10,10'd5,18'h00000,1'b0,1'b1,1'b1,18'h0ABCD},
        '{1'b0,1'b1,1'b0,1'b1,2'b00,10'd5,18'h00000,1'b0,1'b0,1'b0,18'h00000},
        '{1'b1,1'b1,1'b0,1'b1,2'b00,10'd5,18'h3FFFF,1'b0,1'b0,1'b0,18'h00000},
        '{1'b0,1'b0,1'b0,1'b1,2'b00,10'd5,18'h3FFFF,1'b0,1'b1,1'b1,18'h123FF},
        '{1'b0,1'b0,1'b1,1'b0,2'b00,10'd5,18'h00000,1'b0,1'b0,1'b0,18'h00000},
        '{1'b0,1'b1,1'b0,1'b1,2'b00,10'd6,18'h00000,1'b0,1'b0,1'b0,18'h00000},
        '{1'b0,1'b0,1'b1,1'b0,2'b00,10'd5,18'h00000,1'b0,1'b1,1'b1,18'h0ABCD},
        '{1'b0,1'b1,1'b0,1'b1,2'b00,10'd6,18'h00000,1'b1,1'b1,1'b0,18'h123FF},
        '{1'b0,1'b1,1'b0,1'b0,2'b01,10'd6,18'h00000,1'b0,1'b1,1'b1,18'h0ABCD},
        '{1'b0,1'b1,1'b0,1'b1,2'b00,10'd6,18'h00000,1'b0,1'b0,1'b0,18'h00000},
        '{1'b0,1'b1,1'b0,1'b1,2'b00,10'd6,18'h2AAAA,1'b0,1'b1,1'b1,18'h2ABCD},
        '{1'b0,1'b1,1'b0,1'b0,2'b11,10'd5,18'h00000,1'b0,1'b1,1'b1,18'h2ABCD},
        '{1'b0,1'b0,1'b0,1'b1,2'b00,10'd0,18'h00000,1'b0,1'b0,1'b0,18'h00000},
        '{1'b0,1'b1,1'b0,1'b1,2'b00,10'd5,18'h3FFFF,1'b0,1'b0,1'b0,18'h00000},
        '{1'b0,1'b0,1'b0,1'b1,2'b00,10'd0,18'h00000,1'b0,1'b1,1'b1,18'h123FF},
        '{1'b0,1'b0,1'b0,1'b1,2'b00,10'd0,18'h00000,1'b0,1'b0,1'b0,18'h00000}
    };

    function automatic string row_tag(input int i);
        case (i)
            0, 1, 2:  return "R6";
            3:        return "R3";
            4:        return "R2";
            5:        return "R6";
            6:        return "R4";
            7:        return "R5";
            8:        return "R11";
            9:        return "R7";
            10:       return "R11";
            11:       return "R9";
            12:       return "R2";
            13:       return "R6";
            14:       return "R10";
            15:       return "R3";
            16, 17:   return "R7";
            18:       return "R5";
            default:  return "R7";
        endcase
    endfunction

    // Reference state for the directed and random phases.
    logic [DW-1:0] gold [DEPTH];
    logic [DW-1:0] wq0 = '0, wq1 = '0;
    logic          shown_v = 1'b0, pend_v = 1'b0;
    logic [DW-1:0] shown_q = '0, pend_q = '0;

    function automatic logic [DW-1:0] mrg(input logic [DW-1:0] old_w,
                                          input logic [DW-1:0] new_w,
                                          input logic [NL-1:0] bwn);
        logic [DW-1:0] r;
        r = old_w;
        for (int i = 0; i < NL; i++)
            if (!bwn[i]) r[i*LW +: LW] = new_w[i*LW +: LW];
        return r;
    endfunction

    task automatic chk(input string tag, input logic got_d, input logic exp_d,
                       input logic [DW-1:0] got_q, input logic [DW-1:0] exp_q,
                       input logic cmp_q);
        n_chk++;
        if (got_d !== exp_d) begin
            n_bad++;
            $display("FAIL %s drive_en actual %0b expected %0b at %0t", tag, got_d, exp_d, $time);
        end
        if (cmp_q) begin
            n_chk++;
            if (got_q !== exp_q) begin
                n_bad++;
                $display("FAIL %s rdata actual %h expected %h at %0t", tag, got_q, exp_q, $time);
            end
        end
    endtask

    // One cycle of a fresh command (or a stall); starts and ends at a falling edge.
    task automatic op(input logic en_n_i, input logic [2:0] cs_i, input logic wrn_i,
                      input logic [NL-1:0] bw_i, input logic [AW-1:0] a_i,
                      input logic [DW-1:0] d_i, input logic oe_i, input string tag);
        logic ok;
        logic nv;
        logic [DW-1:0] nq;
        ok = (cs_i == 3'b010);
        clk_en_n = en_n_i;
        {sel1_n, sel2, sel3_n} = cs_i;
        load_n = 1'b0; wr_n = wrn_i; bw_n = bw_i;
        addr = a_i; next_addr = a_i; wdata = wq1; oe_n = oe_i;
        if (!en_n_i) begin
            nv = 1'b0; nq = '0;
            if (ok && wrn_i) begin nv = 1'b1; nq = gold[a_i]; end
            if (ok && !wrn_i) gold[a_i] = mrg(gold[a_i], d_i, bw_i);
            shown_v = pend_v; shown_q = pend_q;
            pend_v = nv; pend_q = nq;
            wq1 = wq0; wq0 = d_i;
        end
        @(posedge clk);
        @(negedge clk);
        chk(tag, drive_en, shown_v & ~oe_i, rdata, shown_q, shown_v);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; clk_en_n = 1'b0; oe_n = 1'b0;
        {sel1_n, sel2, sel3_n} = 3'b101;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R8", drive_en, 1'b0, rdata, '0, 1'b1);
        rst_n = 1'b1;
        shown_v = 1'b0; pend_v = 1'b0; wq0 = '0; wq1 = '0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired (all requirements)");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        do_reset();

        // Vector table walk.
        for (int i = 0; i < NV; i++) begin
            clk_en_n = VEC[i].en_n;
            {sel1_n, sel2, sel3_n} = VEC[i].cs ? 3'b010 : 3'b110;
            load_n = VEC[i].ld_n; wr_n = VEC[i].wrn; bw_n = VEC[i].bwn;
            addr = VEC[i].a; next_addr = VEC[i].a;
            wdata = VEC[i].wd; oe_n = VEC[i].oen;
            @(posedge clk);
            @(negedge clk);
            chk(row_tag(i), drive_en, VEC[i].drv, rdata, VEC[i].q, VEC[i].chk);
        end

        do_reset();

        // Fill every word back to back (R3 timing under continuous writes).
        for (int i = 0; i < DEPTH; i++)
            op(1'b0, 3'b010, 1'b0, 2'b00, AW'(i), DW'(i * 37 + 18'h155), 1'b0, "R3");
        op(1'b0, 3'b101, 1'b1, 2'b11, '0, '0, 1'b0, "R7");
        op(1'b0, 3'b101, 1'b1, 2'b11, '0, '0, 1'b0, "R7");

        // Each select held inactive alone must block a read (R1).
        op(1'b0, 3'b110, 1'b1, 2'b11, 10'd3, '0, 1'b0, "R1");
        op(1'b0, 3'b000, 1'b1, 2'b11, 10'd3, '0, 1'b0, "R1");
        op(1'b0, 3'b011, 1'b1, 2'b11, 10'd3, '0, 1'b0, "R1");
        op(1'b0, 3'b010, 1'b1, 2'b11, 10'd3, '0, 1'b0, "R1");
        op(1'b0, 3'b101, 1'b1, 2'b11, 10'd3, '0, 1'b0, "R1");

        // Reset with a read in flight must silence the output (R8).
        op(1'b0, 3'b010, 1'b1, 2'b11, 10'd4, '0, 1'b0, "R2");
        do_reset();
        op(1'b0, 3'b101, 1'b1, 2'b11, '0, '0, 1'b0, "R8");

        // Random back-to-back traffic on a narrow address window.
        for (int k = 0; k < 3000; k++) begin
            int kind;
            logic [AW-1:0] a;
            logic [NL-1:0] bw;
            logic [DW-1:0] d;
            logic oe;
            kind = int'($urandom % 8);
            a  = ($urandom % 4 == 0) ? AW'($urandom) : AW'($urandom % 8);
            bw = NL'($urandom);
            d  = DW'($urandom);
            oe = ($urandom % 5 == 0);
            if (kind < 3)       op(1'b0, 3'b010, 1'b1, bw, a, d, oe, "R10");
            else if (kind < 6)  op(1'b0, 3'b010, 1'b0, bw, a, d, oe, "R5");
            else if (kind == 6) op(1'b1, 3'b010, 1'b0, bw, a, d, oe, "R4");
            else                op(1'b0, 3'b100, 1'b1, bw, a, d, oe, "R7");
        end
        op(1'b0, 3'b101, 1'b1, 2'b11, '0, '0, 1'b0, "R7");
        op(1'b0, 3'b101, 1'b1, 2'b11, '0, '0, 1'b0, "R7");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule